// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Controller

This block gathers the three interrupt sources of a real-time clock: a periodic tick from the divider chain, the end of each once-per-second time update, and a match between the current time and a programmed alarm time. Each source latches a sticky flag. A separate enable gates each flag onto a shared active-low interrupt line. The time counter sits outside this block and supplies the current seconds, minutes and hours bytes, the periodic tick and the update-ended pulse.

Software reads one status byte. That byte shows the combined request, the three flags and a constant validity bit, and the read clears every flag. The three enables are loaded together by one write strobe. Reset clears them, and a rising edge of the clock-hold (SET) control clears the update enable only.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The status byte carries the combined request in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bit 3 is a validity bit that always reads 1, reset included. Bits 2 to 0 read 0.
- R2: A `periodicTick` pulse sets the periodic flag on the next clock edge, whatever the periodic enable is.
- R3: An `updateDone` pulse sets the update flag on the next clock edge, whatever the update enable is.
- R4: On an `updateDone` pulse, the alarm flag is set when all three alarm bytes match the time bytes. It is never set without that pulse, and it is not set when any one byte mismatches.
- R5: An alarm byte with bits 7:6 equal to 11 matches any time value. A byte with any other top-bit pattern matches only an identical value.
- R6: The combined request is (periodic AND PIE) OR (alarm AND AIE) OR (update AND UIE), and `irqN` is its inverse.
- R7: A `statusRead` pulse clears all three flags, and with them the combined request, from the next clock edge.
- R8: When a flag-setting event arrives in the same cycle as `statusRead`, that flag reads 1 afterwards.
- R9: `enWrite` loads the enables from `enData`, with PIE in bit 2, AIE in bit 1 and UIE in bit 0. Reset clears all enables and all flags.
- R10: A 0-to-1 transition of `setBit` clears UIE and leaves PIE and AIE unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodicTick | input | 1 | One-cycle pulse from the selected divider tap |
| updateDone | input | 1 | One-cycle pulse when a time update completes |
| secNow | input | 8 | Current seconds byte |
| minNow | input | 8 | Current minutes byte |
| hrNow | input | 8 | Current hours byte |
| secAlarm | input | 8 | Alarm seconds byte |
| minAlarm | input | 8 | Alarm minutes byte |
| hrAlarm | input | 8 | Alarm hours byte |
| enWrite | input | 1 | Strobe that loads the enables |
| enData | input | 3 | New enables: PIE bit 2, AIE bit 1, UIE bit 0 |
| setBit | input | 1 | Clock-hold control level |
| statusRead | input | 1 | Strobe marking a status byte read |
| statusByte | output | 8 | Request, flags and validity bit |
| irqN | output | 1 | Active-low interrupt request |

## Verification
On every cycle, the assertions check the following: each tick and update pulse leaves its flag set, the alarm flag rises only after an update pulse, a status read with no competing event clears the upper nibble, a rising SET leaves UIE clear, and the line stays idle while every enable is off. The other behaviours need the bench's scenarios:
- the full combined-request truth table over enables and flags;
- the exact-match and wildcard sweeps across all three alarm bytes;
- a read colliding with an event;
- a reset arriving in the middle of a run.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int STATUS_W  = 8;
  localparam int BIT_REQ   = 7;
  localparam int BIT_PER   = 6;
  localparam int BIT_ALM   = 5;
  localparam int BIT_UPD   = 4;
  localparam int BIT_VALID = 3;
  localparam int N_BYTES   = 3;

  typedef struct packed {
    logic clrFlags;
    logic setPer;
    logic doUpdate;
    logic wrEnables;
    logic clrUie;
  } irqStrobes_t;
endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        periodicTick,
  input  logic        updateDone,
  input  logic        enWrite,
  input  logic        setBit,
  input  logic        statusRead,
  output irqStrobes_t strobes
);
  logic setPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) setPrev <= 1'b0;
    else       setPrev <= setBit;
  end

  always_comb begin
    strobes.clrFlags  = statusRead;
    strobes.setPer    = periodicTick;
    strobes.doUpdate  = updateDone;
    strobes.wrEnables = enWrite;
    strobes.clrUie    = setBit && !setPrev;
  end
endmodule

// File: rtl/rtc_irq_dp.sv
module rtc_irq_dp
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strobes,
  input  logic [DATA_W-1:0] timeNow  [N_BYTES],
  input  logic [DATA_W-1:0] alarmVal [N_BYTES],
  input  logic [2:0]        enData,
  output logic              perQ,
  output logic              almQ,
  output logic              updQ,
  output logic              pieQ,
  output logic              aieQ,
  output logic              uieQ
);
  localparam int WILD_W = 2;
  localparam logic [WILD_W-1:0] WILD_CODE = '1;

  logic [N_BYTES-1:0] byteHit;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_cmp
    logic wild;
    assign wild       = alarmVal[i][DATA_W-1 -: WILD_W] == WILD_CODE;
    assign byteHit[i] = wild || (alarmVal[i] == timeNow[i]);
  end

  logic alarmHit;
  assign alarmHit = &byteHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perQ <= 1'b0;
      almQ <= 1'b0;
      updQ <= 1'b0;
    end else begin
      perQ <= strobes.setPer                 || (perQ && !strobes.clrFlags);
      updQ <= strobes.doUpdate               || (updQ && !strobes.clrFlags);
      almQ <= (strobes.doUpdate && alarmHit) || (almQ && !strobes.clrFlags);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pieQ <= 1'b0;
      aieQ <= 1'b0;
      uieQ <= 1'b0;
    end else begin
      if (strobes.wrEnables) begin
        pieQ <= enData[2];
        aieQ <= enData[1];
      end
      if (strobes.clrUie)         uieQ <= 1'b0;
      else if (strobes.wrEnables) uieQ <= enData[0];
    end
  end

  assert_tick_sets_per_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setPer |=> perQ);
  assert_update_sets_upd_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doUpdate |=> updQ);
  assert_alarm_only_on_update_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(almQ) |-> $past(strobes.doUpdate));
  assert_collision_keeps_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrFlags && strobes.setPer) |=> perQ);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periodicTick,
  input  logic              updateDone,
  input  logic [DATA_W-1:0] secNow,
  input  logic [DATA_W-1:0] minNow,
  input  logic [DATA_W-1:0] hrNow,
  input  logic [DATA_W-1:0] secAlarm,
  input  logic [DATA_W-1:0] minAlarm,
  input  logic [DATA_W-1:0] hrAlarm,
  input  logic              enWrite,
  input  logic [2:0]        enData,
  input  logic              setBit,
  input  logic              statusRead,
  output logic [STATUS_W-1:0] statusByte,
  output logic              irqN
);
  irqStrobes_t strobes;
  logic perQ, almQ, updQ, pieQ, aieQ, uieQ;
  logic reqFlag;
  logic [DATA_W-1:0] timeArr  [N_BYTES];
  logic [DATA_W-1:0] alarmArr [N_BYTES];

  assign timeArr[0]  = secNow;
  assign timeArr[1]  = minNow;
  assign timeArr[2]  = hrNow;
  assign alarmArr[0] = secAlarm;
  assign alarmArr[1] = minAlarm;
  assign alarmArr[2] = hrAlarm;

  rtc_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .periodicTick(periodicTick), .updateDone(updateDone),
    .enWrite(enWrite), .setBit(setBit), .statusRead(statusRead), .strobes(strobes)
  );

  rtc_irq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .timeNow(timeArr), .alarmVal(alarmArr),
    .enData(enData), .perQ(perQ), .almQ(almQ), .updQ(updQ),
    .pieQ(pieQ), .aieQ(aieQ), .uieQ(uieQ)
  );

  assign reqFlag = (perQ && pieQ) || (almQ && aieQ) || (updQ && uieQ);
  assign irqN    = !reqFlag;

  always_comb begin
    statusByte            = '0;
    statusByte[BIT_REQ]   = reqFlag;
    statusByte[BIT_PER]   = perQ;
    statusByte[BIT_ALM]   = almQ;
    statusByte[BIT_UPD]   = updQ;
    statusByte[BIT_VALID] = 1'b1;
  end

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !periodicTick && !updateDone) |=> (statusByte[7:4] == 4'b0000));
  assert_set_rise_clears_uie_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setBit) |=> !uieQ);
  assert_idle_when_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!pieQ && !aieQ && !uieQ) |-> irqN);
endmodule

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periodicTick = 0, updateDone = 0, enWrite = 0, setBit = 0, statusRead = 0;
  logic [7:0] secNow = 8'h30, minNow = 8'h15, hrNow = 8'h07;
  logic [7:0] secAlarm = 8'h00, minAlarm = 8'h00, hrAlarm = 8'h00;
  logic [2:0] enData = 3'b000;
  logic [7:0] statusByte;
  logic irqN;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtc_alarm_irq u_rtc_alarm_irq (
    .clk(clk), .rstN(rstN), .periodicTick(periodicTick), .updateDone(updateDone),
    .secNow(secNow), .minNow(minNow), .hrNow(hrNow),
    .secAlarm(secAlarm), .minAlarm(minAlarm), .hrAlarm(hrAlarm),
    .enWrite(enWrite), .enData(enData), .setBit(setBit), .statusRead(statusRead),
    .statusByte(statusByte), .irqN(irqN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle of stimulus driven at a falling edge; outputs visible at the next one.
  task automatic cycle(input logic tick, input logic upd, input logic rd);
    periodicTick = tick; updateDone = upd; statusRead = rd;
    @(negedge clk);
    periodicTick = 0; updateDone = 0; statusRead = 0;
  endtask

  task automatic writeEn(input logic [2:0] e);
    enData = e; enWrite = 1;
    @(negedge clk);
    enWrite = 0;
  endtask

  function automatic logic [7:0] expStatus(logic [2:0] en, logic p, logic a, logic u);
    logic req;
    req = (p && en[2]) || (a && en[1]) || (u && en[0]);
    return {req, p, a, u, 1'b1, 3'b000};
  endfunction

  function automatic logic [7:0] almPick(int mode, logic [7:0] t);
    case (mode)
      0: return t;
      1: return t ^ 8'h01;
      2: return 8'hC0;
      3: return 8'hFF;
      default: return 8'h80 | t;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 R9 reset status", statusByte, 8'h08);
    check("R6 R9 reset irqN", {7'b0, irqN}, 8'h01);
    rstN = 1;
    @(negedge clk);

    // R6 truth table sweep; flag pattern f: bit2 per, bit1 alarm, bit0 update
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 8; f++) begin
        if (f[1] && !f[0]) continue;
        cycle(0, 0, 1);
        writeEn(e[2:0]);
        secAlarm = f[1] ? secNow : 8'h00;
        minAlarm = minNow; hrAlarm = hrNow;
        if (f[2] || f[0]) cycle(f[2], f[0], 0);
        check("R1 R2 R3 R6 status", statusByte, expStatus(e[2:0], f[2], f[1], f[0]));
        check("R6 irqN", {7'b0, irqN}, {7'b0, !expStatus(e[2:0], f[2], f[1], f[0])[7]});
      end
    end

    // R4 R5 alarm match sweep across all three bytes
    writeEn(3'b010);
    for (int ms = 0; ms < 5; ms++) begin
      for (int mm = 0; mm < 5; mm++) begin
        for (int mh = 0; mh < 5; mh++) begin
          logic hit;
          cycle(0, 0, 1);
          secAlarm = almPick(ms, secNow);
          minAlarm = almPick(mm, minNow);
          hrAlarm  = almPick(mh, hrNow);
          hit = (ms == 0 || ms == 2 || ms == 3) && (mm == 0 || mm == 2 || mm == 3) &&
                (mh == 0 || mh == 2 || mh == 3);
          cycle(1, 0, 0);
          check("R4 no alarm without update", statusByte, expStatus(3'b010, 1, 0, 0));
          cycle(0, 1, 0);
          check("R4 R5 alarm compare", statusByte, expStatus(3'b010, 1, hit, 1));
        end
      end
    end

    // R7 read clears everything
    cycle(0, 0, 1);
    check("R7 read clears", statusByte, 8'h08);

    // R8 collisions with a read
    writeEn(3'b111);
    secAlarm = secNow; minAlarm = minNow; hrAlarm = hrNow;
    cycle(1, 0, 0);
    cycle(1, 0, 1);
    check("R8 tick with read", statusByte, expStatus(3'b111, 1, 0, 0));
    cycle(0, 1, 1);
    check("R8 update with read", statusByte, expStatus(3'b111, 0, 1, 1));

    // R10 SET rise clears UIE only
    cycle(0, 0, 1);
    setBit = 1;
    @(negedge clk);
    cycle(0, 0, 1);
    secAlarm = 8'h00;
    cycle(0, 1, 0);
    check("R10 update irq masked", {7'b0, irqN}, 8'h01);
    cycle(0, 0, 1);
    cycle(1, 0, 0);
    check("R10 PIE kept", {7'b0, irqN}, 8'h00);
    cycle(0, 0, 1);
    secAlarm = secNow;
    cycle(0, 1, 0);
    check("R10 AIE kept", statusByte, expStatus(3'b110, 0, 1, 1));
    setBit = 0;

    // R9 reset in the middle of a run
    writeEn(3'b111);
    cycle(1, 1, 0);
    rstN = 0;
    #1;
    check("R9 async reset status", statusByte, 8'h08);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    cycle(1, 1, 0);
    check("R9 enables cleared", {7'b0, irqN}, 8'h01);
    check("R9 R1 flags after reset", statusByte, 8'h78);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule